// File: doc/BRIEF.md
# Dual-Stream Time-Sliced Pixel Processing Element

This block runs two independent 12-bit pixel streams through a single gain, offset and clamp datapath. Clock cycles are split into alternating slots, one for each stream. Each stream has a one-entry holding buffer. A ready signal goes back to its source, so each source can deliver at most one pixel every two cycles. When both streams deliver a pixel in the same cycle, the slot schedule pushes one of the two pixels into the next free slot, so the two never compete for the datapath.

Each stream has its own pair of configuration contexts. Software writes a shadow context through a small write port, and the shadow can be written while pixels are flowing. The shadow becomes the active context for a stream only when a pixel carrying that stream's frame-start marker enters the datapath. A slot tag travels down the pipeline with each pixel and steers the result into that stream's own output register, together with the stream's own valid and frame-start flags. The operand register in front of the datapath loads only in slots that carry a pixel, so the arithmetic sees no toggling while the block is idle.

Top module: `ds_pixel_pe`

## Requirements
- R1: Slots alternate every cycle, starting with stream 1 in the first cycle after reset. As a result, all stream 1 results appear on cycles of one parity and all stream 2 results appear on cycles of the other parity.
- R2: After reset both ready outputs are high. A stream's ready output is low in the cycle after that stream has a pixel accepted (valid and ready both high at a clock edge).
- R3: Pixels accepted on both streams at the same edge are both processed. Their results leave exactly one cycle apart, and the two output valids are never high together.
- R4: With the enable bit set, the result is ((pixel × gain) >> 4) + offset. Gain is unsigned 8-bit with 4 fraction bits. Offset is a signed 13-bit two's-complement value.
- R5: A result below 0 becomes 0, and a result above 4095 becomes 4095.
- R6: With the enable bit clear, the pixel passes through unchanged. After reset each context holds gain 0x10, offset 0 and enable clear.
- R7: Each stream has its own context, selected by the slot that owns the pixel. A write with cfg_sel_i = 0 targets stream 1 and a write with cfg_sel_i = 1 targets stream 2. A write for one stream never changes the results of the other stream.
- R8: A context write takes effect for that stream starting with the first pixel accepted after the write that has its frame-start input high. Pixels without the marker that are accepted after the write still use the previous context.
- R9: The frame-start flag on each output equals the frame-start input that arrived with that pixel.
- R10: A result appears at its stream's output after the 3rd clock edge following the accepting edge when the next cycle is that stream's slot, and after the 4th edge otherwise.
- R11: Each output valid is a one-cycle pulse, one pulse per accepted pixel. Between pulses the output pixel and flag hold their last values. After reset they are zero.
- R12: In slots that carry no pixel, the datapath operand register keeps its value, and the outputs stay unchanged during idle periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s1_pix_i | input | 12 | Stream 1 input pixel |
| s1_valid_i | input | 1 | Stream 1 pixel valid |
| s1_sof_i | input | 1 | Stream 1 frame-start marker |
| s1_ready_o | output | 1 | Stream 1 can accept a pixel |
| s2_pix_i | input | 12 | Stream 2 input pixel |
| s2_valid_i | input | 1 | Stream 2 pixel valid |
| s2_sof_i | input | 1 | Stream 2 frame-start marker |
| s2_ready_o | output | 1 | Stream 2 can accept a pixel |
| cfg_we_i | input | 1 | Shadow context write strobe |
| cfg_sel_i | input | 1 | Target stream (0 = stream 1, 1 = stream 2) |
| cfg_gain_i | input | 8 | Gain, unsigned, 4 fraction bits |
| cfg_ofs_i | input | 13 | Offset, signed |
| cfg_en_i | input | 1 | Arithmetic enable (0 = pass through) |
| o1_pix_o | output | 12 | Stream 1 result |
| o1_valid_o | output | 1 | Stream 1 result valid pulse |
| o1_sof_o | output | 1 | Stream 1 result frame-start flag |
| o2_pix_o | output | 12 | Stream 2 result |
| o2_valid_o | output | 1 | Stream 2 result valid pulse |
| o2_sof_o | output | 1 | Stream 2 result frame-start flag |

## Verification
The bench builds the block with its package defaults: 12-bit pixels, an 8-bit gain with 4 fraction bits, a 13-bit offset and two streams. With these values every gain and offset code can be reached from random stimulus, so both clamp rails and the pass-through path are all hit many times. The 1-bit slot tag puts the one-cycle conflict shift and the 3-or-4-edge latency split within reach of every simultaneous arrival.

// File: rtl/ds_pe_pkg.sv
package ds_pe_pkg;
  localparam int PIX_W     = 12;
  localparam int GAIN_W    = 8;
  localparam int GAIN_FRAC = 4;
  localparam int OFS_W     = 13;
  localparam int N_STR     = 2;
  localparam int TAG_W     = (N_STR > 1) ? $clog2(N_STR) : 1;
  localparam int PROD_W    = PIX_W + GAIN_W;
  localparam int SCL_W     = PROD_W - GAIN_FRAC;
  localparam int SUM_W     = ((SCL_W > OFS_W) ? SCL_W : OFS_W) + 2;
  localparam int PIX_MAX   = (1 << PIX_W) - 1;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [OFS_W-1:0]  ofs;
    logic              en;
  } ctx_t;

  localparam ctx_t CTX_RST = '{gain: GAIN_W'(1 << GAIN_FRAC), ofs: '0, en: 1'b0};

  typedef struct packed {
    logic             v;
    logic             sof;
    logic [PIX_W-1:0] pix;
  } beat_t;
endpackage

// File: rtl/ds_pe_resync.sv
module ds_pe_resync
  import ds_pe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  beat_t            in_i [N_STR],
  output logic [N_STR-1:0] ready_o,
  output beat_t            issue_o,
  output logic [TAG_W-1:0] issue_tag_o
);
  logic [TAG_W-1:0] slot_q;
  beat_t            buf_q [N_STR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         slot_q <= '0;
    else if (slot_q == TAG_W'(N_STR-1))  slot_q <= '0;
    else                                 slot_q <= slot_q + 1'b1;
  end

  for (genvar g = 0; g < N_STR; g++) begin : g_buf
    assign ready_o[g] = !buf_q[g].v;

    // a full buffer only drains in its own slot; an empty one only fills
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          buf_q[g] <= '0;
      else if (in_i[g].v && ready_o[g])     buf_q[g] <= in_i[g];
      else if (slot_q == TAG_W'(g))         buf_q[g].v <= 1'b0;
    end
  end

  // data selector: slot owner feeds the datapath
  assign issue_o     = buf_q[slot_q];
  assign issue_tag_o = slot_q;
endmodule

// File: rtl/ds_pe_ctx_bank.sv
module ds_pe_ctx_bank
  import ds_pe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [TAG_W-1:0] cfg_sel_i,
  input  ctx_t             cfg_ctx_i,
  input  logic             issue_v_i,
  input  logic             issue_sof_i,
  input  logic [TAG_W-1:0] issue_tag_i,
  output ctx_t             ctx_o
);
  ctx_t shadow_q [N_STR];
  ctx_t active_q [N_STR];
  logic swap;

  assign swap = issue_v_i && issue_sof_i;

  for (genvar g = 0; g < N_STR; g++) begin : g_ctx
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  shadow_q[g] <= CTX_RST;
      else if (cfg_we_i && cfg_sel_i == TAG_W'(g))  shadow_q[g] <= cfg_ctx_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  active_q[g] <= CTX_RST;
      else if (swap && issue_tag_i == TAG_W'(g))    active_q[g] <= shadow_q[g];
    end
  end

  // frame-start pixel already uses the context it promotes
  assign ctx_o = swap ? shadow_q[issue_tag_i] : active_q[issue_tag_i];
endmodule

// File: rtl/ds_pe_datapath.sv
module ds_pe_datapath
  import ds_pe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  beat_t            issue_i,
  input  logic [TAG_W-1:0] issue_tag_i,
  input  ctx_t             ctx_i,
  output logic             res_v_o,
  output logic [TAG_W-1:0] res_tag_o,
  output logic [PIX_W-1:0] res_pix_o,
  output logic             res_sof_o,
  output logic [PIX_W-1:0] op_pix_o
);
  // isolation operand stage
  logic             op_v_q, op_sof_q;
  logic [TAG_W-1:0] op_tag_q;
  logic [PIX_W-1:0] op_pix_q;
  ctx_t             op_ctx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_v_q   <= 1'b0;
      op_sof_q <= 1'b0;
      op_tag_q <= '0;
      op_pix_q <= '0;
      op_ctx_q <= CTX_RST;
    end else begin
      op_v_q <= issue_i.v;
      if (issue_i.v) begin
        op_sof_q <= issue_i.sof;
        op_tag_q <= issue_tag_i;
        op_pix_q <= issue_i.pix;
        op_ctx_q <= ctx_i;
      end
    end
  end

  assign op_pix_o = op_pix_q;

  // scale stage
  logic [PROD_W-1:0] prod;
  assign prod = {{GAIN_W{1'b0}}, op_pix_q} * {{PIX_W{1'b0}}, op_ctx_q.gain};

  logic             p_v_q, p_sof_q, p_en_q;
  logic [TAG_W-1:0] p_tag_q;
  logic [PIX_W-1:0] p_pix_q;
  logic [SCL_W-1:0] p_scl_q;
  logic [OFS_W-1:0] p_ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_v_q   <= 1'b0;
      p_sof_q <= 1'b0;
      p_en_q  <= 1'b0;
      p_tag_q <= '0;
      p_pix_q <= '0;
      p_scl_q <= '0;
      p_ofs_q <= '0;
    end else begin
      p_v_q <= op_v_q;
      if (op_v_q) begin
        p_sof_q <= op_sof_q;
        p_en_q  <= op_ctx_q.en;
        p_tag_q <= op_tag_q;
        p_pix_q <= op_pix_q;
        p_scl_q <= prod[PROD_W-1:GAIN_FRAC];
        p_ofs_q <= op_ctx_q.ofs;
      end
    end
  end

  // offset and clamp, registered by the per-stream output stage
  logic [SUM_W-1:0] sum;
  logic [PIX_W-1:0] clamped;

  assign sum = {{(SUM_W-SCL_W){1'b0}}, p_scl_q}
             + {{(SUM_W-OFS_W){p_ofs_q[OFS_W-1]}}, p_ofs_q};

  always_comb begin
    if (sum[SUM_W-1])                  clamped = '0;
    else if (sum > SUM_W'(PIX_MAX))    clamped = PIX_W'(PIX_MAX);
    else                               clamped = sum[PIX_W-1:0];
  end

  assign res_v_o   = p_v_q;
  assign res_tag_o = p_tag_q;
  assign res_sof_o = p_sof_q;
  assign res_pix_o = p_en_q ? clamped : p_pix_q;
endmodule

// File: rtl/ds_pe_outreg.sv
module ds_pe_outreg
  import ds_pe_pkg::*;
#(
  parameter int ID = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_v_i,
  input  logic [TAG_W-1:0] res_tag_i,
  input  logic [PIX_W-1:0] res_pix_i,
  input  logic             res_sof_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             valid_o,
  output logic             sof_o
);
  logic hit;
  assign hit = res_v_i && (res_tag_i == TAG_W'(ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
    end else begin
      valid_o <= hit;
      if (hit) begin
        pix_o <= res_pix_i;
        sof_o <= res_sof_i;
      end
    end
  end
endmodule

// File: rtl/ds_pixel_pe.sv
module ds_pixel_pe
  import ds_pe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  s1_pix_i,
  input  logic              s1_valid_i,
  input  logic              s1_sof_i,
  output logic              s1_ready_o,
  input  logic [PIX_W-1:0]  s2_pix_i,
  input  logic              s2_valid_i,
  input  logic              s2_sof_i,
  output logic              s2_ready_o,
  input  logic              cfg_we_i,
  input  logic [TAG_W-1:0]  cfg_sel_i,
  input  logic [GAIN_W-1:0] cfg_gain_i,
  input  logic [OFS_W-1:0]  cfg_ofs_i,
  input  logic              cfg_en_i,
  output logic [PIX_W-1:0]  o1_pix_o,
  output logic              o1_valid_o,
  output logic              o1_sof_o,
  output logic [PIX_W-1:0]  o2_pix_o,
  output logic              o2_valid_o,
  output logic              o2_sof_o
);
  beat_t            in_beat [N_STR];
  logic [N_STR-1:0] rdy;
  beat_t            issue;
  logic [TAG_W-1:0] issue_tag;
  ctx_t             cfg_ctx, cur_ctx;
  logic             issue_v;
  logic             res_v, res_sof;
  logic [TAG_W-1:0] res_tag;
  logic [PIX_W-1:0] res_pix;
  logic [PIX_W-1:0] op_pix;

  assign in_beat[0] = '{v: s1_valid_i, sof: s1_sof_i, pix: s1_pix_i};
  assign in_beat[1] = '{v: s2_valid_i, sof: s2_sof_i, pix: s2_pix_i};
  assign s1_ready_o = rdy[0];
  assign s2_ready_o = rdy[1];
  assign cfg_ctx    = '{gain: cfg_gain_i, ofs: cfg_ofs_i, en: cfg_en_i};
  assign issue_v    = issue.v;

  ds_pe_resync u_resync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_i        (in_beat),
    .ready_o     (rdy),
    .issue_o     (issue),
    .issue_tag_o (issue_tag)
  );

  ds_pe_ctx_bank u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_ctx_i   (cfg_ctx),
    .issue_v_i   (issue.v),
    .issue_sof_i (issue.sof),
    .issue_tag_i (issue_tag),
    .ctx_o       (cur_ctx)
  );

  ds_pe_datapath u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .issue_tag_i (issue_tag),
    .ctx_i       (cur_ctx),
    .res_v_o     (res_v),
    .res_tag_o   (res_tag),
    .res_pix_o   (res_pix),
    .res_sof_o   (res_sof),
    .op_pix_o    (op_pix)
  );

  logic [PIX_W-1:0] out_pix [N_STR];
  logic [N_STR-1:0] out_v, out_sof;

  for (genvar g = 0; g < N_STR; g++) begin : g_out
    ds_pe_outreg #(.ID(g)) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .res_v_i   (res_v),
      .res_tag_i (res_tag),
      .res_pix_i (res_pix),
      .res_sof_i (res_sof),
      .pix_o     (out_pix[g]),
      .valid_o   (out_v[g]),
      .sof_o     (out_sof[g])
    );
  end

  assign o1_pix_o   = out_pix[0];
  assign o1_valid_o = out_v[0];
  assign o1_sof_o   = out_sof[0];
  assign o2_pix_o   = out_pix[1];
  assign o2_valid_o = out_v[1];
  assign o2_sof_o   = out_sof[1];
endmodule

// File: rtl/ds_pe_chk.sv
module ds_pe_chk
  import ds_pe_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             s1_valid_i,
  input logic             s1_ready_o,
  input logic             s2_valid_i,
  input logic             s2_ready_o,
  input logic             o1_valid_o,
  input logic             o2_valid_o,
  input logic [PIX_W-1:0] o1_pix_o,
  input logic [PIX_W-1:0] o2_pix_o,
  input logic             issue_v,
  input logic [PIX_W-1:0] op_pix
);
  // R2
  s1_accept_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_i && s1_ready_o) |=> !s1_ready_o);
  // R2
  s2_accept_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_valid_i && s2_ready_o) |=> !s2_ready_o);
  // R3
  out_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(o1_valid_o && o2_valid_o));
  // R11
  o1_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o1_valid_o |=> !o1_valid_o);
  // R11
  o2_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o2_valid_o |=> !o2_valid_o);
  // R11
  o1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !o1_valid_o |-> $stable(o1_pix_o));
  // R11
  o2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !o2_valid_o |-> $stable(o2_pix_o));
  // R12
  operand_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_v |=> $stable(op_pix));
endmodule

bind ds_pixel_pe ds_pe_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s1_valid_i (s1_valid_i),
  .s1_ready_o (s1_ready_o),
  .s2_valid_i (s2_valid_i),
  .s2_ready_o (s2_ready_o),
  .o1_valid_o (o1_valid_o),
  .o2_valid_o (o2_valid_o),
  .o1_pix_o   (o1_pix_o),
  .o2_pix_o   (o2_pix_o),
  .issue_v    (issue_v),
  .op_pix     (op_pix)
);

// File: tb/test_ds_pixel_pe.sv
module test_ds_pixel_pe;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] s1_pix_i = '0, s2_pix_i = '0;
  logic        s1_valid_i = 1'b0, s1_sof_i = 1'b0, s2_valid_i = 1'b0, s2_sof_i = 1'b0;
  logic        s1_ready_o, s2_ready_o;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0, cfg_en_i = 1'b0;
  logic [7:0]  cfg_gain_i = '0;
  logic [12:0] cfg_ofs_i = '0;
  logic [11:0] o1_pix_o, o2_pix_o;
  logic        o1_valid_o, o1_sof_o, o2_valid_o, o2_sof_o;

  ds_pixel_pe i_ds_pixel_pe (.*);

  always #2.5ns clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  int sh_g[2], sh_o[2], ac_g[2], ac_o[2];
  bit sh_e[2], ac_e[2];
  int    exp_pix[2][$];
  bit    exp_sof[2][$];
  int    exp_cyc[2][$];
  string exp_tag[2][$];
  string phase_tag[2];
  bit    acc_prev[2];
  int    last_cyc[2];
  int    par[2];

  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model(int pix, int g, int o, bit e);
    int r;
    if (!e) return pix;
    r = ((pix * g) >>> 4) + o;
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  task automatic push(int s, int pix, bit sof);
    int r, raw;
    string t;
    if (sof) begin ac_g[s] = sh_g[s]; ac_o[s] = sh_o[s]; ac_e[s] = sh_e[s]; end
    r = model(pix, ac_g[s], ac_o[s], ac_e[s]);
    raw = ((pix * ac_g[s]) >>> 4) + ac_o[s];
    if (phase_tag[s] != "") t = phase_tag[s];
    else if (!ac_e[s]) t = "R6";
    else if (raw < 0 || raw > 4095) t = "R5";
    else t = "R4";
    exp_pix[s].push_back(r);
    exp_sof[s].push_back(sof);
    exp_cyc[s].push_back(cyc + 1);
    exp_tag[s].push_back(t);
  endtask

  task automatic chk_out(int s, bit v, int pix, bit sof);
    int ep, ec, lat;
    bit es;
    string et;
    if (!v) return;
    if (exp_pix[s].size() == 0) begin
      check(1'b0, "R11", 1, 0, $sformatf("unexpected result on stream %0d", s + 1));
      return;
    end
    ep = exp_pix[s].pop_front(); es = exp_sof[s].pop_front();
    ec = exp_cyc[s].pop_front(); et = exp_tag[s].pop_front();
    check(pix == ep, et, pix, ep, $sformatf("stream %0d result", s + 1));
    check(sof == es, "R9", int'(sof), int'(es), $sformatf("stream %0d sof", s + 1));
    lat = cyc - ec;
    check(lat == 3 || lat == 4, "R10", lat, 3, $sformatf("stream %0d latency", s + 1));
    // R1: fixed parity per stream, opposite between streams
    if (par[s] < 0) par[s] = cyc % 2;
    else check(cyc % 2 == par[s], "R1", cyc % 2, par[s], "slot parity");
    if (par[0] >= 0 && par[1] >= 0)
      check(par[0] != par[1], "R1", par[0], 1 - par[1], "streams share parity");
    last_cyc[s] = cyc;
  endtask

  always @(negedge clk_i) if (rst_ni && !done) begin
    chk_out(0, o1_valid_o, int'(o1_pix_o), o1_sof_o);
    chk_out(1, o2_valid_o, int'(o2_pix_o), o2_sof_o);
  end

  task automatic drive(bit v1, int p1, bit f1, bit v2, int p2, bit f2);
    bit a1, a2;
    if (acc_prev[0]) check(!s1_ready_o, "R2", int'(s1_ready_o), 0, "s1 ready after accept");
    if (acc_prev[1]) check(!s2_ready_o, "R2", int'(s2_ready_o), 0, "s2 ready after accept");
    s1_valid_i = v1; s1_pix_i = p1[11:0]; s1_sof_i = f1;
    s2_valid_i = v2; s2_pix_i = p2[11:0]; s2_sof_i = f2;
    a1 = v1 && s1_ready_o;
    a2 = v2 && s2_ready_o;
    if (a1) push(0, p1, f1);
    if (a2) push(1, p2, f2);
    acc_prev[0] = a1; acc_prev[1] = a2;
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic idle(int n);
    repeat (n) drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic cfg_write(int s, int g, int o, bit e);
    cfg_we_i = 1'b1; cfg_sel_i = s[0]; cfg_gain_i = g[7:0]; cfg_ofs_i = o[12:0]; cfg_en_i = e;
    sh_g[s] = g; sh_o[s] = o; sh_e[s] = e;
    drive(0, 0, 0, 0, 0, 0);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #600us;
    if (!done) begin
      check(1'b0, "watchdog", cyc, 0, "run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5c));
    for (int s = 0; s < 2; s++) begin
      sh_g[s] = 16; sh_o[s] = 0; sh_e[s] = 0;
      ac_g[s] = 16; ac_o[s] = 0; ac_e[s] = 0;
      phase_tag[s] = ""; par[s] = -1; acc_prev[s] = 0; last_cyc[s] = 0;
    end
    repeat (3) @(negedge clk_i);
    // reset state: R2 and R11
    check(s1_ready_o && s2_ready_o, "R2", int'(s1_ready_o & s2_ready_o), 1, "ready in reset");
    check(!o1_valid_o && !o2_valid_o, "R11", int'(o1_valid_o | o2_valid_o), 0, "valid in reset");
    check(o1_pix_o == 0 && o2_pix_o == 0, "R11", int'(o1_pix_o | o2_pix_o), 0, "pixels in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // default context passes through (R6)
    drive(1, 1234, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 77, 1);
    idle(6);

    // R8: write while stream 2 runs; R7: independent contexts
    cfg_write(0, 8'h18, 100, 1);
    drive(0, 0, 0, 1, 500, 0);
    idle(2);
    phase_tag[0] = "R8";
    drive(1, 1000, 0, 0, 0, 0);
    idle(2);
    drive(1, 1000, 1, 0, 0, 0);
    idle(2);
    phase_tag[0] = "";
    phase_tag[1] = "R7";
    drive(0, 0, 0, 1, 1000, 0);
    idle(2);
    cfg_write(1, 8'h08, -50, 1);
    drive(0, 0, 0, 1, 1000, 1);
    idle(2);
    drive(1, 1000, 0, 0, 0, 0);
    idle(6);
    phase_tag[1] = "";

    // R3: simultaneous arrival
    drive(1, 100, 0, 1, 200, 0);
    idle(8);
    check(last_cyc[0] - last_cyc[1] == 1 || last_cyc[1] - last_cyc[0] == 1, "R3",
          last_cyc[0] - last_cyc[1], 1, "spacing of simultaneous results");
    drive(0, 0, 0, 1, 300, 0);
    drive(1, 400, 0, 1, 301, 0);
    idle(8);

    // R5: both clamp rails
    cfg_write(0, 8'hFF, 4095, 1);
    cfg_write(1, 8'h01, -4096, 1);
    drive(1, 4095, 1, 1, 4095, 1);
    idle(2);
    drive(1, 0, 0, 1, 16, 0);
    idle(8);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if (i % 400 == 399) begin
        idle(3);
        cfg_write(0, int'($urandom % 256), int'($urandom % 8192) - 4096, ($urandom % 5) != 0);
        cfg_write(1, int'($urandom % 256), int'($urandom % 8192) - 4096, ($urandom % 5) != 0);
      end
      drive(($urandom % 10) < 6, int'($urandom % 4096), ($urandom % 20) == 0,
            ($urandom % 10) < 6, int'($urandom % 4096), ($urandom % 20) == 0);
    end
    idle(8);
    check(exp_pix[0].size() == 0 && exp_pix[1].size() == 0, "R11",
          exp_pix[0].size() + exp_pix[1].size(), 0, "results missing");

    // R12: idle outputs stay put
    begin
      logic [11:0] h1, h2;
      bit quiet;
      h1 = o1_pix_o; h2 = o2_pix_o; quiet = 1'b1;
      for (int k = 0; k < 10; k++) begin
        drive(0, 0, 0, 0, 0, 0);
        if (o1_valid_o || o2_valid_o || o1_pix_o != h1 || o2_pix_o != h2) quiet = 1'b0;
      end
      check(quiet, "R12", int'(quiet), 1, "outputs during idle");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule